// File: doc/BRIEF.md
# In-Order DMA Read Requester

This engine fetches a linear region of memory that may be much larger than one read request is allowed to be, and delivers the words to a sink that can only take them in ascending address order. A command supplies a base address, a byte length and a selector for the largest request size. The engine cuts the region into requests no larger than that size. Only the last request of a transfer may be shorter.

Completions for one request may be split into several parts. The parts of a single request never overtake one another. Completions of different requests, however, can overtake each other. For that reason the engine keeps exactly one request open at a time. It issues the next one only once the final completion word of the current one has arrived. Every completion word carries the tag of its request, the number of bytes still owed for that request (this word included) and a flag that marks the end of a part. The engine checks these fields against its own count and tag. Words that do not fit are dropped and raise a sticky error flag. A one-cycle done pulse follows the last word of the transfer written to the sink.

Top module: `ordered_rd_engine`

## Requirements
- R1: After reset the engine issues no request, presents no sink word, and holds done low and the error flag low.
- R2: Each request length equals the smaller of the bytes not yet requested and the maximum request size. The maximum is 128 << sel bytes, for sel = 0, 1, 2, 3 (128, 256, 512 or 1024 bytes). It is sampled when the command is accepted, and later changes to the selector have no effect on that transfer.
- R3: The first request address equals the command base. Each following request address equals the previous address plus the previous length.
- R4: After a request handshake no further request is presented until the completion word with byte count equal to one word (4 bytes) has been accepted. The next request is presented in the cycle right after that word.
- R5: While a request is presented and not yet taken, its address, length and tag stay stable.
- R6: The request tag is 0 after reset and advances by one (modulo 32) from each request to the next, across transfers.
- R7: Each accepted completion word appears on the sink one cycle later, in arrival order. The sink's last flag is set only on the final word of the transfer.
- R8: A completion word is dropped and sets the error flag in any of these cases: its tag differs from the open request's tag; its byte count differs from the bytes still owed; it owes exactly one word yet does not close its part; or it arrives while no request is open. The flag stays set until the next accepted command, which clears it.
- R9: Done pulses for one cycle, in the cycle after the sink's last word. A zero-length command produces done in the cycle after it is accepted, with no request.
- R10: A command presented while a transfer is in progress is ignored.
- R11: A request whose completion arrives in several parts stays open through every part boundary. It closes only when the owed byte count is exhausted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken only when idle |
| start_addr | input | ADDR_W | Base byte address, word aligned |
| start_len | input | LEN_W | Transfer length in bytes, a multiple of 4 |
| max_rd_sel | input | 2 | Maximum request size selector (128 << sel bytes) |
| rd_req_valid | output | 1 | A read request is presented |
| rd_req_ready | input | 1 | The request is taken this cycle |
| rd_req_addr | output | ADDR_W | Request byte address |
| rd_req_len | output | 11 | Request length in bytes |
| rd_req_tag | output | TAG_W | Request tag |
| cpl_valid | input | 1 | A completion word is present |
| cpl_tag | input | TAG_W | Tag of the request the word belongs to |
| cpl_bcnt | input | 11 | Bytes still owed for the request, this word included |
| cpl_eop | input | 1 | This word ends a completion part |
| cpl_data | input | DATA_W | Completion data word |
| sink_valid | output | 1 | A word is written to the sink |
| sink_data | output | DATA_W | Sink data word |
| sink_last | output | 1 | Final word of the transfer |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| xfer_err | output | 1 | Sticky completion error flag |

## Verification
The assertions check, on every cycle, the rules that are local in time. Nothing is presented right after a handshake, and a pending request holds steady. Tags step by one between requests, and request lengths stay within bounds and word aligned. Every sink word traces back to a completion word, done follows the last word, and the error flag only rises after a completion word. Only the bench's scenarios can show the rest: that the splitting hits the exact size boundaries for every selector, that addresses and data stay contiguous and in order across many requests, that a faulty word is dropped rather than forwarded, and that a command arriving mid-transfer or of zero length behaves as specified.

// File: rtl/ordrd_pkg.sv
package ordrd_pkg;

    localparam int REQ_LEN_W = 11;
    localparam int SEL_W     = 2;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ISSUE = 2'd1,
        ENG_WAIT  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic accept;
        logic bad_tag;
        logic bad_count;
        logic bad_close;
        logic stray;
    } cpl_verdict_t;

    function automatic logic [REQ_LEN_W-1:0] max_req_bytes(input logic [SEL_W-1:0] sel);
        return REQ_LEN_W'(128) << sel;
    endfunction

endpackage

// File: rtl/ordrd_splitter.sv
module ordrd_splitter import ordrd_pkg::*; #(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0]     remaining,
    input  logic [SEL_W-1:0]     size_sel,
    output logic [REQ_LEN_W-1:0] chunk
);
    logic [LEN_W-1:0] cap;

    always_comb begin
        cap = LEN_W'(max_req_bytes(size_sel));
        if (remaining <= cap) begin
            chunk = REQ_LEN_W'(remaining);
        end else begin
            chunk = max_req_bytes(size_sel);
        end
    end
endmodule

// File: rtl/ordrd_cpl_check.sv
module ordrd_cpl_check import ordrd_pkg::*; #(
    parameter int TAG_W      = 5,
    parameter int BEAT_BYTES = 4
) (
    input  logic                 beat_valid,
    input  logic                 waiting,
    input  logic [TAG_W-1:0]     want_tag,
    input  logic [REQ_LEN_W-1:0] want_count,
    input  logic [TAG_W-1:0]     beat_tag,
    input  logic [REQ_LEN_W-1:0] beat_count,
    input  logic                 beat_close,
    output cpl_verdict_t         verdict
);
    localparam logic [REQ_LEN_W-1:0] LAST_COUNT = REQ_LEN_W'(BEAT_BYTES);

    always_comb begin
        verdict.stray     = beat_valid && !waiting;
        verdict.bad_tag   = beat_valid && waiting && (beat_tag != want_tag);
        verdict.bad_count = beat_valid && waiting && (beat_count != want_count);
        verdict.bad_close = beat_valid && waiting && (beat_count == LAST_COUNT) && !beat_close;
        verdict.accept    = beat_valid && waiting && !verdict.bad_tag
                            && !verdict.bad_count && !verdict.bad_close;
    end
endmodule

// File: rtl/ordrd_out_stage.sv
module ordrd_out_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_fire,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_final,
    input  logic              empty_finish,
    output logic              sink_valid,
    output logic [DATA_W-1:0] sink_data,
    output logic              sink_last,
    output logic              xfer_done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sink_valid <= 1'b0;
            sink_last  <= 1'b0;
            xfer_done  <= 1'b0;
        end else begin
            sink_valid <= word_fire;
            sink_last  <= word_fire && word_final;
            xfer_done  <= (sink_valid && sink_last) || empty_finish;
        end
    end

    always_ff @(posedge clk) begin
        if (word_fire) begin
            sink_data <= word_data;
        end
    end
endmodule

// File: rtl/ordered_rd_engine.sv
module ordered_rd_engine import ordrd_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    start_addr,
    input  logic [LEN_W-1:0]     start_len,
    input  logic [SEL_W-1:0]     max_rd_sel,
    output logic                 rd_req_valid,
    input  logic                 rd_req_ready,
    output logic [ADDR_W-1:0]    rd_req_addr,
    output logic [REQ_LEN_W-1:0] rd_req_len,
    output logic [TAG_W-1:0]     rd_req_tag,
    input  logic                 cpl_valid,
    input  logic [TAG_W-1:0]     cpl_tag,
    input  logic [REQ_LEN_W-1:0] cpl_bcnt,
    input  logic                 cpl_eop,
    input  logic [DATA_W-1:0]    cpl_data,
    output logic                 sink_valid,
    output logic [DATA_W-1:0]    sink_data,
    output logic                 sink_last,
    output logic                 xfer_done,
    output logic                 xfer_err
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam logic [REQ_LEN_W-1:0] BEAT_REQ = REQ_LEN_W'(BEAT_BYTES);
    localparam logic [LEN_W-1:0]     BEAT_LEN = LEN_W'(BEAT_BYTES);

    eng_state_e           state_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [LEN_W-1:0]     left_q;
    logic [REQ_LEN_W-1:0] pend_q;
    logic [TAG_W-1:0]     tag_q;
    logic [SEL_W-1:0]     sel_q;
    logic                 err_q;

    logic [REQ_LEN_W-1:0] chunk;
    cpl_verdict_t         verdict;
    logic                 take_start;
    logic                 empty_start;
    logic                 req_closed;
    logic                 word_final;
    logic                 bad_word;

    ordrd_splitter #(.LEN_W(LEN_W)) u_split (
        .remaining (left_q),
        .size_sel  (sel_q),
        .chunk     (chunk)
    );

    ordrd_cpl_check #(.TAG_W(TAG_W), .BEAT_BYTES(BEAT_BYTES)) u_check (
        .beat_valid (cpl_valid),
        .waiting    (state_q == ENG_WAIT),
        .want_tag   (tag_q),
        .want_count (pend_q),
        .beat_tag   (cpl_tag),
        .beat_count (cpl_bcnt),
        .beat_close (cpl_eop),
        .verdict    (verdict)
    );

    assign take_start  = start && (state_q == ENG_IDLE);
    assign empty_start = take_start && (start_len == '0);
    assign req_closed  = verdict.accept && (pend_q == BEAT_REQ);
    assign word_final  = req_closed && (left_q == BEAT_LEN);
    assign bad_word    = verdict.stray || verdict.bad_tag || verdict.bad_count || verdict.bad_close;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            pend_q  <= '0;
            tag_q   <= '0;
            sel_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (take_start) begin
                        addr_q <= start_addr;
                        left_q <= start_len;
                        sel_q  <= max_rd_sel;
                        err_q  <= 1'b0;
                        if (start_len != '0) begin
                            state_q <= ENG_ISSUE;
                        end
                    end
                end
                ENG_ISSUE: begin
                    if (rd_req_ready) begin
                        pend_q  <= chunk;
                        addr_q  <= addr_q + ADDR_W'(chunk);
                        state_q <= ENG_WAIT;
                    end
                end
                ENG_WAIT: begin
                    if (verdict.accept) begin
                        pend_q <= pend_q - BEAT_REQ;
                        left_q <= left_q - BEAT_LEN;
                        if (req_closed) begin
                            tag_q   <= tag_q + TAG_W'(1);
                            state_q <= word_final ? ENG_IDLE : ENG_ISSUE;
                        end
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
            if (bad_word) begin
                err_q <= 1'b1;
            end
        end
    end

    assign rd_req_valid = (state_q == ENG_ISSUE);
    assign rd_req_addr  = addr_q;
    assign rd_req_len   = chunk;
    assign rd_req_tag   = tag_q;
    assign xfer_err     = err_q;

    ordrd_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk          (clk),
        .rst          (rst),
        .word_fire    (verdict.accept),
        .word_data    (cpl_data),
        .word_final   (word_final),
        .empty_finish (empty_start),
        .sink_valid   (sink_valid),
        .sink_data    (sink_data),
        .sink_last    (sink_last),
        .xfer_done    (xfer_done)
    );
endmodule

// File: rtl/ordrd_sva.sv
module ordrd_sva import ordrd_pkg::*; #(
    parameter int ADDR_W     = 32,
    parameter int TAG_W      = 5,
    parameter int BEAT_BYTES = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rd_req_valid,
    input logic                 rd_req_ready,
    input logic [ADDR_W-1:0]    rd_req_addr,
    input logic [REQ_LEN_W-1:0] rd_req_len,
    input logic [TAG_W-1:0]     rd_req_tag,
    input logic                 cpl_valid,
    input logic                 sink_valid,
    input logic                 sink_last,
    input logic                 xfer_done,
    input logic                 xfer_err
);
    logic [TAG_W-1:0] last_tag_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q     <= 1'b0;
            last_tag_q <= '0;
        end else if (rd_req_valid && rd_req_ready) begin
            seen_q     <= 1'b1;
            last_tag_q <= rd_req_tag;
        end
    end

    assert_one_open_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && rd_req_ready) |=> !rd_req_valid);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !rd_req_ready) |=>
            (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len) && $stable(rd_req_tag)));

    assert_tag_step_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && rd_req_ready && seen_q) |-> (rd_req_tag == last_tag_q + TAG_W'(1)));

    assert_req_size_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> ((rd_req_len != '0) && (rd_req_len <= REQ_LEN_W'(1024))
                          && ((rd_req_len % REQ_LEN_W'(BEAT_BYTES)) == '0)));

    assert_sink_cause_R7: assert property (@(posedge clk) disable iff (rst)
        sink_valid |-> $past(cpl_valid));

    assert_done_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        (sink_valid && sink_last) |=> xfer_done);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_err) |-> $past(cpl_valid));
endmodule

bind ordered_rd_engine ordrd_sva #(
    .ADDR_W     (ADDR_W),
    .TAG_W      (TAG_W),
    .BEAT_BYTES (DATA_W / 8)
) u_sva (
    .clk          (clk),
    .rst          (rst),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_req_len   (rd_req_len),
    .rd_req_tag   (rd_req_tag),
    .cpl_valid    (cpl_valid),
    .sink_valid   (sink_valid),
    .sink_last    (sink_last),
    .xfer_done    (xfer_done),
    .xfer_err     (xfer_err)
);

// File: tb/ordered_rd_engine_tb.sv
module ordered_rd_engine_tb;
    import ordrd_pkg::*;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 5;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst;
    logic                 start;
    logic [ADDR_W-1:0]    start_addr;
    logic [LEN_W-1:0]     start_len;
    logic [SEL_W-1:0]     max_rd_sel;
    logic                 rd_req_valid;
    logic                 rd_req_ready;
    logic [ADDR_W-1:0]    rd_req_addr;
    logic [REQ_LEN_W-1:0] rd_req_len;
    logic [TAG_W-1:0]     rd_req_tag;
    logic                 cpl_valid;
    logic [TAG_W-1:0]     cpl_tag;
    logic [REQ_LEN_W-1:0] cpl_bcnt;
    logic                 cpl_eop;
    logic [DATA_W-1:0]    cpl_data;
    logic                 sink_valid;
    logic [DATA_W-1:0]    sink_data;
    logic                 sink_last;
    logic                 xfer_done;
    logic                 xfer_err;

    ordered_rd_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .start_len(start_len),
        .max_rd_sel(max_rd_sel), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len), .rd_req_tag(rd_req_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_bcnt(cpl_bcnt), .cpl_eop(cpl_eop),
        .cpl_data(cpl_data), .sink_valid(sink_valid), .sink_data(sink_data),
        .sink_last(sink_last), .xfer_done(xfer_done), .xfer_err(xfer_err)
    );

    int errors = 0;
    int checks = 0;

    logic [TAG_W-1:0]  tag_ref = '0;
    logic [ADDR_W-1:0] mon_base = '0;
    int                mon_words = 0;
    int                mon_idx = 0;
    bit                prev_last = 1'b0;
    bit                zero_ok = 1'b0;

    function automatic logic [31:0] wdata(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[31:16] + a[15:0]};
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Sink monitor: order, data, last flag and done pulse (R7, R9)
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_last) chk("R9 done in cycle after last word", 64'(xfer_done), 64'(1));
            else if (xfer_done && !zero_ok) chk("R9 spurious done", 64'(xfer_done), 64'(0));
            if (sink_valid) begin
                if (mon_idx >= mon_words) begin
                    chk("R7 unexpected sink word", 64'(mon_idx), 64'(mon_words));
                end else begin
                    chk("R7 sink data in address order", 64'(sink_data),
                        64'(wdata(mon_base + 32'(4 * mon_idx))));
                    chk("R7 sink last flag", 64'(sink_last), 64'(mon_idx == mon_words - 1));
                end
                mon_idx++;
            end
            prev_last = sink_valid && sink_last;
        end
    end

    // fault: 0 none, 1 wrong tag, 2 byte count gap, 3 final word without part close
    task automatic run_xfer(input logic [31:0] base, input int len, input int sel,
                            input int part, input int fault, input bit poke);
        int          left;
        logic [31:0] a;
        int          mr;
        bit          first;
        left  = len;
        a     = base;
        mr    = 128 << sel;
        first = 1'b1;
        @(negedge clk);
        mon_base   = base;
        mon_words  = len / 4;
        mon_idx    = 0;
        start      = 1'b1;
        start_addr = base;
        start_len  = LEN_W'(len);
        max_rd_sel = SEL_W'(sel);
        @(negedge clk);
        start      = 1'b0;
        max_rd_sel = SEL_W'(sel + 1);  // R2: later selector change must not matter
        chk("R8 accepted command clears error", 64'(xfer_err), 64'(0));
        while (left > 0) begin
            int ch;
            int w;
            ch = (left < mr) ? left : mr;
            w  = 0;
            while (!rd_req_valid && w < 40) begin
                @(negedge clk);
                w++;
            end
            chk("R3 request address", 64'(rd_req_addr), 64'(a));
            chk("R2 request length", 64'(rd_req_len), 64'(ch));
            chk("R6 request tag", 64'(rd_req_tag), 64'(tag_ref));
            if (poke) begin
                start      = 1'b1;
                start_addr = 32'hDEAD_0000;
                start_len  = LEN_W'(8);
                @(negedge clk);
                start = 1'b0;
                chk("R10 busy command ignored, addr", 64'(rd_req_addr), 64'(a));
                chk("R5 pending request held", 64'(rd_req_valid), 64'(1));
            end
            rd_req_ready = 1'b1;
            @(negedge clk);
            rd_req_ready = 1'b0;
            chk("R4 nothing presented after handshake", 64'(rd_req_valid), 64'(0));
            if (first && (fault == 1 || fault == 2)) begin
                cpl_valid = 1'b1;
                cpl_tag   = (fault == 1) ? tag_ref + TAG_W'(1) : tag_ref;
                cpl_bcnt  = (fault == 2) ? REQ_LEN_W'(ch + 4) : REQ_LEN_W'(ch);
                cpl_eop   = 1'b1;
                cpl_data  = 32'hBAD0_BAD0;
                @(negedge clk);
                cpl_valid = 1'b0;
                chk("R8 faulty word dropped", 64'(sink_valid), 64'(0));
                chk("R8 faulty word flags error", 64'(xfer_err), 64'(1));
            end
            for (int o = 0; o < ch; o += 4) begin
                if (o > 0) chk("R4/R11 request still open across parts", 64'(rd_req_valid), 64'(0));
                if (first && fault == 3 && o == ch - 4) begin
                    cpl_valid = 1'b1;
                    cpl_tag   = tag_ref;
                    cpl_bcnt  = REQ_LEN_W'(4);
                    cpl_eop   = 1'b0;
                    cpl_data  = 32'hBAD1_BAD1;
                    @(negedge clk);
                    cpl_valid = 1'b0;
                    chk("R8 unclosed final word dropped", 64'(sink_valid), 64'(0));
                    chk("R8 unclosed final word flags error", 64'(xfer_err), 64'(1));
                end
                cpl_valid = 1'b1;
                cpl_tag   = tag_ref;
                cpl_bcnt  = REQ_LEN_W'(ch - o);
                cpl_eop   = (((o + 4) % part) == 0) || (o + 4 == ch);
                cpl_data  = wdata(a + 32'(o));
                @(negedge clk);
            end
            cpl_valid = 1'b0;
            left  -= ch;
            a     += 32'(ch);
            tag_ref = tag_ref + TAG_W'(1);
            first = 1'b0;
            if (left > 0) chk("R4 next request right after final word", 64'(rd_req_valid), 64'(1));
        end
        @(negedge clk);
        @(negedge clk);
        chk("R7 all words delivered", 64'(mon_idx), 64'(len / 4));
        chk("R8 error flag state at end", 64'(xfer_err), 64'(fault != 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; start_addr = '0; start_len = '0; max_rd_sel = '0;
        rd_req_ready = 1'b0; cpl_valid = 1'b0; cpl_tag = '0; cpl_bcnt = '0;
        cpl_eop = 1'b0; cpl_data = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 no request after reset", 64'(rd_req_valid), 64'(0));
        chk("R1 no sink word after reset", 64'(sink_valid), 64'(0));
        chk("R1 done low after reset", 64'(xfer_done), 64'(0));
        chk("R1 error low after reset", 64'(xfer_err), 64'(0));
        chk("R6 tag zero after reset", 64'(rd_req_tag), 64'(0));

        // Sweep every size selector across the split boundaries
        for (int sel = 0; sel < 4; sel++) begin
            for (int k = 0; k < 6; k++) begin
                int mr;
                int len;
                mr = 128 << sel;
                case (k)
                    0: len = 4;
                    1: len = mr - 4;
                    2: len = mr;
                    3: len = mr + 4;
                    4: len = 2 * mr + 12;
                    default: len = 3 * mr;
                endcase
                run_xfer(32'h4000_0000 + 32'(sel << 16) + 32'(k << 12) + 32'(8 * k),
                         len, sel, 4 << (2 * (k % 3)), 0, k == 2);
            end
        end

        // Zero-length command (R9)
        zero_ok = 1'b1;
        @(negedge clk);
        start = 1'b1; start_addr = 32'h0000_1000; start_len = '0; max_rd_sel = '0;
        @(negedge clk);
        start = 1'b0;
        chk("R9 zero-length done", 64'(xfer_done), 64'(1));
        chk("R9 zero-length no request", 64'(rd_req_valid), 64'(0));
        @(negedge clk);
        chk("R9 zero-length done is one cycle", 64'(xfer_done), 64'(0));
        zero_ok = 1'b0;

        // Faulty completion words (R8)
        run_xfer(32'h5000_0000, 600, 1, 64, 1, 1'b0);
        run_xfer(32'h5001_0000, 300, 0, 16, 2, 1'b0);
        run_xfer(32'h5002_0000, 200, 2, 32, 3, 1'b0);

        // Stray word while idle (R8)
        @(negedge clk);
        cpl_valid = 1'b1; cpl_tag = tag_ref; cpl_bcnt = REQ_LEN_W'(4); cpl_eop = 1'b1;
        cpl_data = 32'hBAD2_BAD2;
        @(negedge clk);
        cpl_valid = 1'b0;
        chk("R8 stray word dropped", 64'(sink_valid), 64'(0));
        chk("R8 stray word flags error", 64'(xfer_err), 64'(1));
        @(negedge clk);
        chk("R8 error sticky while idle", 64'(xfer_err), 64'(1));

        // Long transfer, many requests, tag wrap (R6)
        run_xfer(32'h6000_0000, 8192, 0, 128, 0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule